// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM that uses 18-bit words. Each word is split into two 9-bit byte lanes. The address, the control inputs and the write data are all captured on the rising clock edge. A two-bit counter produces the low address bits during a burst. Reads leave through an output register by default. The `flow_thru` pin bypasses that register so that data arrives one edge earlier. The output drivers are gated combinationally by an active-low output enable and by a sleep input.

A burst begins when either of two strobes is low. One strobe belongs to the processor side and is honoured only while `cs_n` is low. The other belongs to the controller side. The start address is stored, and later cycles either step the low two bits or hold them. The step order is linear or interleaved, selected by `burst_linear`. Writes may be whole-word or per lane. Three chip selects allow several devices to share a bus. A start cycle with any select inactive deselects the device. In pipelined mode the data bus is released on the second edge after that start cycle.

The full device addresses 19 bits. Here `ADDR_W` (default 8, which gives 256 words) sets the depth, and the low two address bits always come from the burst logic.

Top module: `pburst_sram`

## Requirements
- R1: A start with `ctl_strb_n` low loads `addr`; when `cs_n`=0, `cs_hi`=1 and `cs2_n`=0 the word at `addr` is accessed in that same cycle, as a write or a read according to R6.
- R2: With `cs_n` low, a start by `cpu_strb_n` low is always a read of `addr`, whatever the write inputs are. With `cs_n` high, `cpu_strb_n` is ignored.
- R3: With `burst_linear`=1, each non-start cycle with `step_n`=0 sets the low two address bits to (start + n) mod 4, where n counts steps since the start. The upper bits stay fixed.
- R4: With `burst_linear`=0, the low two address bits become start XOR n.
- R5: A non-start cycle with `step_n`=1 accesses the same word again.
- R6: If `all_wr_n`=0, both lanes are written. Otherwise, if `lane_wr_en_n`=0, lane i is written when `lane_sel_n[i]`=0. Lane 0 is `wdata[8:0]` and lane 1 is `wdata[17:9]`. An access that writes no lane is a read.
- R7: Read data is driven after the second clock edge that follows the address sample in pipelined mode (`flow_thru`=0), and after the first edge in flow-through mode.
- R8: A start cycle with any select inactive deselects the device. In pipelined mode `dq_drive` is low after the second edge. Non-start cycles while deselected do nothing.
- R9: `out_en_n`=1 forces `dq_drive` low at once, without waiting for a clock edge.
- R10: While `sleep`=1 there is no read and no write, `dq_drive` is low, and the array contents and burst state are kept.
- R11: After `rst_n` is low at an edge, the device is deselected and `dq_drive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address |
| cpu_strb_n | input | 1 | Processor-side start strobe, active low |
| ctl_strb_n | input | 1 | Controller-side start strobe, active low |
| step_n | input | 1 | Burst step, active low |
| burst_linear | input | 1 | 1 = linear order, 0 = interleaved order |
| all_wr_n | input | 1 | Whole-word write, active low |
| lane_wr_en_n | input | 1 | Enables the per-lane write selects, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| cs_n | input | 1 | Chip select, active low; also gates `cpu_strb_n` |
| cs_hi | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Second chip select, active low |
| out_en_n | input | 1 | Output driver enable, active low, asynchronous |
| flow_thru | input | 1 | 1 = output register bypassed |
| sleep | input | 1 | Power-down |
| wdata | input | LANE_W*LANES | Write data |
| dq_out | output | LANE_W*LANES | Read data |
| dq_drive | output | 1 | High when the data bus is driven |

## Verification
A wrong stored burst count or a wrong base shows up as a read of the wrong word on the very next driven cycle of the burst. A select flag that is stuck set or stuck clear shows up as `dq_drive` disagreeing with the expected value one or two edges after a deselect or a start, depending on the output mode. A wrong lane mask shows only when the word is read back later. For that reason the bench fills the array first and then mixes partial writes with later reads, so that every stored word is compared again afterwards.

// File: rtl/sram_pkg.sv
package sram_pkg;

   // Low address bits for burst position cnt from start bits base
   function automatic logic [1:0] burst_low(input logic [1:0] base,
                                            input logic [1:0] cnt,
                                            input logic       linear);
      return linear ? (base + cnt) : (base ^ cnt);
   endfunction

   typedef enum logic [1:0] {CYC_CONT, CYC_START, CYC_DESEL} cyc_kind_t;

endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
   import sram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              cpu_strb_n,
   input  logic              ctl_strb_n,
   input  logic              step_n,
   input  logic              burst_linear,
   input  logic              all_wr_n,
   input  logic              lane_wr_en_n,
   input  logic [LANES-1:0]  lane_sel_n,
   input  logic              cs_n,
   input  logic              cs_hi,
   input  logic              cs2_n,
   input  logic              sleep,
   output logic [ADDR_W-1:0] acc_addr,
   output logic              acc_rd,
   output logic [LANES-1:0]  acc_wr,
   output logic              desel_ev
);
   localparam int HI_W = ADDR_W - 2;

   logic [HI_W-1:0]  hi_q;
   logic [1:0]       base_q, cnt_q, cnt_nx;
   logic             sel_q, sel_nx;
   logic             cpu_go, start, cs_ok, live;
   logic [LANES-1:0] wr_req;
   cyc_kind_t        kind;

   always_comb begin
      cpu_go = !cpu_strb_n && !cs_n;
      start  = cpu_go || !ctl_strb_n;
      cs_ok  = !cs_n && cs_hi && !cs2_n;
      kind   = !start ? CYC_CONT : (cs_ok ? CYC_START : CYC_DESEL);
      if (kind != CYC_CONT) begin
         cnt_nx   = 2'd0;
         sel_nx   = (kind == CYC_START);
         acc_addr = addr;
      end else begin
         cnt_nx   = step_n ? cnt_q : cnt_q + 2'd1;
         sel_nx   = sel_q;
         acc_addr = {hi_q, burst_low(base_q, cnt_nx, burst_linear)};
      end
      live = rst_n && !sleep && sel_nx;
      for (int i = 0; i < LANES; i++)
         wr_req[i] = !all_wr_n || (!lane_wr_en_n && !lane_sel_n[i]);
      if (cpu_go) wr_req = '0;
      acc_wr   = live ? wr_req : '0;
      acc_rd   = live && (wr_req == '0);
      desel_ev = rst_n && !sleep && (kind == CYC_DESEL);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q   <= '0;
         base_q <= '0;
         cnt_q  <= '0;
         sel_q  <= 1'b0;
      end else if (!sleep) begin
         sel_q <= sel_nx;
         cnt_q <= cnt_nx;
         if (start) begin
            hi_q   <= addr[ADDR_W-1:2];
            base_q <= addr[1:0];
         end
      end
   end

   // R10: burst and select state frozen across a sleep edge
   p_sleep_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> ($stable(hi_q) && $stable(base_q) && $stable(cnt_q) && $stable(sel_q)));

   // R3: a step advances the burst count by one, modulo 4
   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !step_n && !sleep) |=> (cnt_q == $past(cnt_q) + 2'd1));

   // R5: no strobe and no step keeps the burst position
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && step_n && !sleep) |=> ($stable(cnt_q) && $stable(hi_q) && $stable(base_q)));

   // R8: a continuation after a deselect performs no access
   p_desel_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      desel_ev ##1 (!start && !sleep) |-> (!acc_rd && acc_wr == '0));

endmodule

// File: rtl/sram_array.sv
module sram_array #(
   parameter int ADDR_W = 8,
   parameter int LANE_W = 9,
   parameter int LANES  = 2
) (
   input  logic                     clk,
   input  logic [ADDR_W-1:0]        acc_addr,
   input  logic                     acc_rd,
   input  logic [LANES-1:0]         acc_wr,
   input  logic [LANE_W*LANES-1:0]  wdata,
   output logic [LANE_W*LANES-1:0]  rd_data
);
   localparam int DATA_W = LANE_W * LANES;
   localparam int DEPTH  = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] wmask;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign wmask[g*LANE_W +: LANE_W] = {LANE_W{acc_wr[g]}};
   end

   always_ff @(posedge clk) begin
      if (|acc_wr)
         mem[acc_addr] <= (mem[acc_addr] & ~wmask) | (wdata & wmask);
      if (acc_rd)
         rd_data <= mem[acc_addr];
   end

endmodule

// File: rtl/sram_outpath.sv
module sram_outpath #(
   parameter int DATA_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_rd,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              flow_thru,
   input  logic              out_en_n,
   input  logic              sleep,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_drive
);
   logic              vld_en_q, vld_dly_q;
   logic [DATA_W-1:0] out_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_en_q  <= 1'b0;
         vld_dly_q <= 1'b0;
      end else begin
         vld_en_q  <= acc_rd;
         vld_dly_q <= vld_en_q;
      end
   end

   always_ff @(posedge clk) out_q <= rd_data;

   assign dq_out   = flow_thru ? rd_data : out_q;
   assign dq_drive = !out_en_n && !sleep && (flow_thru ? vld_en_q : vld_dly_q);

   // R7: pipelined mode drives only when a read was issued two edges back
   p_pipe_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!flow_thru && dq_drive) |-> $past(acc_rd, 2) || $past(!rst_n, 2));

endmodule

// File: rtl/pburst_sram.sv
module pburst_sram #(
   parameter int ADDR_W = 8,
   parameter int LANE_W = 9,
   parameter int LANES  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    cpu_strb_n,
   input  logic                    ctl_strb_n,
   input  logic                    step_n,
   input  logic                    burst_linear,
   input  logic                    all_wr_n,
   input  logic                    lane_wr_en_n,
   input  logic [LANES-1:0]        lane_sel_n,
   input  logic                    cs_n,
   input  logic                    cs_hi,
   input  logic                    cs2_n,
   input  logic                    out_en_n,
   input  logic                    flow_thru,
   input  logic                    sleep,
   input  logic [LANE_W*LANES-1:0] wdata,
   output logic [LANE_W*LANES-1:0] dq_out,
   output logic                    dq_drive
);
   localparam int DATA_W = LANE_W * LANES;

   if (ADDR_W < 3 || LANE_W < 1 || LANES < 1) begin : g_bad_cfg
      $error("pburst_sram: ADDR_W must be at least 3, LANE_W and LANES at least 1");
   end

   logic [ADDR_W-1:0] acc_addr;
   logic              acc_rd, desel_ev;
   logic [LANES-1:0]  acc_wr;
   logic [DATA_W-1:0] rd_data;

   sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .addr(addr),
      .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n), .step_n(step_n),
      .burst_linear(burst_linear), .all_wr_n(all_wr_n),
      .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
      .cs_n(cs_n), .cs_hi(cs_hi), .cs2_n(cs2_n), .sleep(sleep),
      .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_wr(acc_wr), .desel_ev(desel_ev)
   );

   sram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
      .clk(clk), .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_wr(acc_wr),
      .wdata(wdata), .rd_data(rd_data)
   );

   sram_outpath #(.DATA_W(DATA_W)) u_out (
      .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .rd_data(rd_data),
      .flow_thru(flow_thru), .out_en_n(out_en_n), .sleep(sleep),
      .dq_out(dq_out), .dq_drive(dq_drive)
   );

   // R8: pipelined bus is released by the second edge after a deselect
   p_dcd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      desel_ev |-> ##2 (flow_thru || !dq_drive));

   // R10: sleeping device never drives the bus
   p_sleep_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !dq_drive);

endmodule

// File: tb/sim_pburst_sram.sv
module sim_pburst_sram;
   localparam int AW = 8;
   localparam int DW = 18;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, cpu_strb_n, ctl_strb_n, step_n, burst_linear, all_wr_n;
   logic lane_wr_en_n, cs_n, cs_hi, cs2_n, out_en_n, flow_thru, sleep;
   logic [1:0]    lane_sel_n;
   logic [AW-1:0] addr;
   logic [DW-1:0] wdata, dq_out;
   logic          dq_drive;

   pburst_sram u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .cpu_strb_n(cpu_strb_n),
      .ctl_strb_n(ctl_strb_n), .step_n(step_n), .burst_linear(burst_linear),
      .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
      .cs_n(cs_n), .cs_hi(cs_hi), .cs2_n(cs2_n), .out_en_n(out_en_n),
      .flow_thru(flow_thru), .sleep(sleep), .wdata(wdata),
      .dq_out(dq_out), .dq_drive(dq_drive)
   );

   int nchk = 0, nfail = 0, ncyc = 0;
   string cur_tag = "R11";

   // ---------------- reference model ----------------
   logic [DW-1:0] mm [256];
   logic [5:0]    m_hi;
   logic [1:0]    m_base, m_cnt;
   logic          m_sel, m_v1, m_v2;
   logic [DW-1:0] m_d1, m_d2;
   string         t1 = "R11", t2 = "R11";

   function automatic logic [1:0] low_bits(input logic [1:0] b, input logic [1:0] n,
                                           input logic lin);
      return lin ? b + n : b ^ n;
   endfunction

   function automatic logic [DW-1:0] lane_mask(input logic gw, input logic be,
                                               input logic [1:0] bs);
      logic [DW-1:0] m;
      m[8:0]  = (!gw || (!be && !bs[0])) ? 9'h1FF : 9'h000;
      m[17:9] = (!gw || (!be && !bs[1])) ? 9'h1FF : 9'h000;
      return m;
   endfunction

   always @(posedge clk) begin
      logic cpu, st, ok, rd;
      logic [AW-1:0] ea;
      logic [DW-1:0] wm;
      ncyc++;
      m_v2 = m_v1; m_d2 = m_d1; t2 = t1; t1 = cur_tag;
      rd = 1'b0;
      if (!rst_n) begin
         m_hi = 0; m_base = 0; m_cnt = 0; m_sel = 0; m_v2 = 0;
      end else if (!sleep) begin
         cpu = !cpu_strb_n && !cs_n;
         st  = cpu || !ctl_strb_n;
         ok  = !cs_n && cs_hi && !cs2_n;
         if (st) begin
            ea = addr; m_hi = addr[7:2]; m_base = addr[1:0]; m_cnt = 0; m_sel = ok;
         end else begin
            if (!step_n) m_cnt = m_cnt + 2'd1;
            ea = {m_hi, low_bits(m_base, m_cnt, burst_linear)};
         end
         if (m_sel) begin
            wm = cpu ? '0 : lane_mask(all_wr_n, lane_wr_en_n, lane_sel_n);
            if (wm != '0) mm[ea] = (mm[ea] & ~wm) | (wdata & wm);
            else begin rd = 1'b1; m_d1 = mm[ea]; end
         end
      end
      m_v1 = rd;
      if (ncyc > 150000) begin
         nfail++;
         $display("FAIL R7 watchdog: cycles %0d exp below 150000", ncyc);
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic nop();
      cpu_strb_n = 1; ctl_strb_n = 1; step_n = 1; all_wr_n = 1; lane_wr_en_n = 1;
      lane_sel_n = 2'b11; cs_n = 0; cs_hi = 1; cs2_n = 0; out_en_n = 0; sleep = 0;
   endtask

   task automatic check();
      logic ed;
      logic [DW-1:0] dexp;
      string tg;
      ed   = !out_en_n && !sleep && (flow_thru ? m_v1 : m_v2);
      dexp = flow_thru ? m_d1 : m_d2;
      tg   = sleep ? "R10" : (out_en_n ? "R9" : (flow_thru ? t1 : t2));
      nchk++;
      if (dq_drive !== ed) begin
         nfail++;
         $display("FAIL %s dq_drive got %0b exp %0b", tg, dq_drive, ed);
      end
      if (ed) begin
         nchk++;
         if (dq_out !== dexp) begin
            nfail++;
            $display("FAIL %s dq_out got %h exp %h", tg, dq_out, dexp);
         end
      end
   endtask

   // inputs are set at a falling edge; advance one cycle, check at next falling edge
   task automatic step(input string tag);
      cur_tag = tag;
      @(negedge clk);
      check();
   endtask

   task automatic rd_start(input logic [AW-1:0] a, input string tag);
      nop(); ctl_strb_n = 0; addr = a; step(tag);
   endtask

   initial begin
      void'($urandom(32'd20240517));
      nop(); rst_n = 0; burst_linear = 1; flow_thru = 0; addr = 0; wdata = 0;
      repeat (3) @(negedge clk);
      ctl_strb_n = 0;                // R11: a start during reset must not take effect
      step("R11"); step("R11");
      rst_n = 1; nop(); step("R11");

      // fill the whole array (R1 with whole-word write, R6)
      for (int a = 0; a < 256; a++) begin
         nop(); ctl_strb_n = 0; all_wr_n = 0; addr = a[AW-1:0]; wdata = $urandom;
         step("R1");
      end

      // R1: controller read start, then drain
      rd_start(8'h10, "R1"); nop(); step("R1"); step("R1");

      // R2: processor start with write inputs active is still a read
      nop(); cpu_strb_n = 0; all_wr_n = 0; addr = 8'h21; wdata = 18'h3FFFF; step("R2");
      nop(); step("R2"); step("R2");
      rd_start(8'h21, "R2"); nop(); step("R2");
      // R2: processor strobe with cs_n high is ignored: burst holds
      nop(); cs_n = 1; cpu_strb_n = 0; addr = 8'h55; step("R2"); nop(); step("R2"); step("R2");

      // R3: linear burst from low bits 2
      burst_linear = 1; rd_start(8'h32, "R3");
      for (int i = 0; i < 4; i++) begin nop(); step_n = 0; step("R3"); end
      nop(); step("R3");
      // R4: interleaved burst from low bits 1
      burst_linear = 0; rd_start(8'h45, "R4");
      for (int i = 0; i < 4; i++) begin nop(); step_n = 0; step("R4"); end
      nop(); step("R4"); burst_linear = 1;

      // R5: hold repeats the same word
      rd_start(8'h66, "R5"); for (int i = 0; i < 3; i++) begin nop(); step("R5"); end

      // R6: lane 0 only, lane 1 only, enable off (read), then read back
      nop(); ctl_strb_n = 0; lane_wr_en_n = 0; lane_sel_n = 2'b10; addr = 8'h70;
      wdata = 18'h2A5A5; step("R6");
      nop(); ctl_strb_n = 0; lane_wr_en_n = 0; lane_sel_n = 2'b01; addr = 8'h71;
      wdata = 18'h15A5A; step("R6");
      nop(); ctl_strb_n = 0; lane_wr_en_n = 1; lane_sel_n = 2'b00; addr = 8'h72;
      wdata = 18'h00000; step("R6");
      rd_start(8'h70, "R6"); nop(); step_n = 0; step("R6");
      nop(); step_n = 0; step("R6"); nop(); step("R6"); step("R6");

      // R7: flow-through latency, then back to pipelined
      flow_thru = 1; rd_start(8'h80, "R7"); nop(); step_n = 0; step("R7");
      nop(); step("R7"); flow_thru = 0; rd_start(8'h81, "R7"); nop(); step("R7"); step("R7");

      // R8: deselect then stepping while deselected
      rd_start(8'h90, "R8");
      nop(); ctl_strb_n = 0; cs_hi = 0; addr = 8'h91; step("R8");
      for (int i = 0; i < 3; i++) begin nop(); step_n = 0; step("R8"); end
      nop(); ctl_strb_n = 0; cs2_n = 1; step("R8"); nop(); step("R8");

      // R9: output enable high blocks a pending read
      rd_start(8'hA0, "R9"); nop(); out_en_n = 1; step("R9"); nop(); step("R9");

      // R10: blocked write and kept burst position during sleep
      nop(); ctl_strb_n = 0; all_wr_n = 0; sleep = 1; addr = 8'hB3; wdata = 18'h0; step("R10");
      rd_start(8'hB3, "R10"); nop(); step("R10");
      rd_start(8'hC0, "R10"); nop(); step_n = 0; step("R10");
      nop(); step_n = 0; sleep = 1; step("R10");
      nop(); step_n = 0; step("R10"); nop(); step("R10"); step("R10");

      // constrained random mix
      for (int n = 0; n < 4000; n++) begin
         int k;
         string tg;
         nop();
         if (n % 50 == 0) burst_linear = $urandom % 2;
         if (n % 300 == 0) flow_thru = $urandom % 2;
         k = $urandom % 8;
         case (k)
            0: begin cpu_strb_n = 0; tg = "R2"; end
            1, 2: begin ctl_strb_n = 0; tg = "R1"; end
            3, 4, 5: begin step_n = 0; tg = burst_linear ? "R3" : "R4"; end
            default: tg = "R5";
         endcase
         addr = $urandom; wdata = $urandom;
         all_wr_n = ($urandom % 5 != 0); lane_wr_en_n = $urandom % 2; lane_sel_n = $urandom;
         cs_n = ($urandom % 12 == 0); cs_hi = ($urandom % 12 != 0); cs2_n = ($urandom % 12 == 0);
         out_en_n = ($urandom % 10 == 0); sleep = ($urandom % 25 == 0);
         step(tg);
      end

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule